// File: doc/BRIEF.md
# Two-Phase Rail Power-Up Sequencer

This block orders the start-up of a group of supply rails that a soft-start ramp brings up. Once bias power is present and no shutdown is requested, it starts the standby rail's ramp. When the external comparator model reports that this ramp has reached its top, the block arms the standby undervoltage monitor and fires a fast-discharge pulse. It then waits a fixed configuration timeout. At the end of that timeout it latches the two dual-rail keep-alive options and the memory-voltage select in one strobe.

The next step depends on the wake requests. If either sleep request is low, the sleep path applies and the second ramp starts at once with the main-supply switches off. If both requests are high, the active path applies. The block then waits until the 3.3 V, 5 V and 12 V inputs have all been good for a settling timeout in a row. After that it starts the second ramp and, in the same cycle, turns on the main-supply switch drive and the clock rail. When the second ramp completes, the remaining monitors are armed, a second discharge pulse fires, and the block stays in the running phase.

The soft-start capacitor is modelled as digital events. The block drives the ramp start and the discharge, and the consuming logic decodes the rail states. Removing bias or asserting shutdown returns the block to its reset phase. A complete new cycle runs once the condition clears.

Top module: `rail_startup_sequencer`

## Requirements
- R1: While rst_n is low, and in the cycle after bias_ok is low or shdn_req is high, phase is 0 (reset) and ramp_go, main_sw_on, clk_rail_on, mon_sb_en, mon_main_en, fast_dis and cfg_stb are all low.
- R2: In the reset phase with bias_ok high and shdn_req low, the next cycle has phase 1 (standby ramp) with ramp_go high and the switch drive and clock rail low.
- R3: ramp_top high in phase 1 gives, in the next cycle, phase 2 (wait), mon_sb_en high and fast_dis high for exactly one cycle.
- R4: cfg_stb is high for exactly one cycle, the CFG_CYC-th cycle after phase 2 is entered. In that same cycle dual3_q, dual5_q and mem_3v3_q show the values that dual3_keep, dual5_keep and msel_hi had at the strobe edge. mem_3v3_q = 1 means the 3.3 V memory setting and 0 means 2.5 V.
- R5: If slp3_n and slp5_n are not both high in the cycle after the strobe, phase 3 (main ramp) follows one cycle after the strobe, with main_sw_on and clk_rail_on low.
- R6: If both requests are high, phase 3 starts after good_3v3, good_5v and good_12v have all been high for SETTLE_CYC consecutive edges counted from the strobe. main_sw_on and clk_rail_on rise in the same cycle as ramp_go.
- R7: A single edge with any main-supply-good input low during the settling wait restarts the count from zero.
- R8: ramp_top high in phase 3 gives, in the next cycle, phase 4 (running), mon_main_en high and a one-cycle fast_dis pulse. The switch drive level is kept.
- R9: Changes on dual3_keep, dual5_keep or msel_hi at any time other than the strobe edge leave the latched outputs unchanged.
- R10: After shutdown is released, a full new cycle runs with both monitors disarmed until their ramps complete, and a fresh latch is taken.
- R11: ramp_top outside phases 1 and 3 changes neither the phase nor fast_dis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_ok | input | 1 | Bias supply past its power-on threshold |
| shdn_req | input | 1 | Shutdown request, active high |
| slp3_n | input | 1 | Suspend-to-RAM request, low = sleep |
| slp5_n | input | 1 | Soft-off request, low = sleep |
| good_3v3 | input | 1 | 3.3 V main input good |
| good_5v | input | 1 | 5 V main input good |
| good_12v | input | 1 | 12 V main input good |
| ramp_top | input | 1 | Soft-start ramp reached its completion level |
| dual3_keep | input | 1 | Option: 3.3 V dual rail kept in deep sleep |
| dual5_keep | input | 1 | Option: 5 V dual rail kept in sleep |
| msel_hi | input | 1 | Memory-select comparator output (1 = high voltage on pin) |
| phase | output | 3 | 0 reset, 1 standby ramp, 2 wait, 3 main ramp, 4 running |
| ramp_go | output | 1 | Soft-start ramp enable |
| fast_dis | output | 1 | One-cycle fast-discharge pulse |
| cfg_stb | output | 1 | One-cycle configuration latch strobe |
| mon_sb_en | output | 1 | Standby rail undervoltage monitor armed |
| mon_main_en | output | 1 | Remaining undervoltage monitors armed |
| main_sw_on | output | 1 | Main-supply switch drive for the dual rails |
| clk_rail_on | output | 1 | Clock rail enable |
| dual3_q | output | 1 | Latched 3.3 V dual keep option |
| dual5_q | output | 1 | Latched 5 V dual keep option |
| mem_3v3_q | output | 1 | Latched memory select, 1 = 3.3 V, 0 = 2.5 V |

## Verification
The checker looks at every cycle for the following. The reset phase must be quiet, and a kill condition must force phase 0. The discharge and strobe pulses may last only one cycle. The latched options may change only together with the strobe. The main monitors may never be armed before the standby monitor. The switch drive and clock rail must rise together and only while a ramp is running. Only the bench's scenarios show the exact timeout lengths, the choice of path from the request pins, and the restart of the settling count after a supply drops. They also show that ramp events outside a ramp phase are ignored, across all eight option settings and all four request combinations.

// File: rtl/rail_startup_sequencer.sv
`timescale 1ns/1ps
module rail_startup_sequencer #(
  parameter int CFG_CYC    = 600000,
  parameter int SETTLE_CYC = 5000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bias_ok,
  input  logic       shdn_req,
  input  logic       slp3_n,
  input  logic       slp5_n,
  input  logic       good_3v3,
  input  logic       good_5v,
  input  logic       good_12v,
  input  logic       ramp_top,
  input  logic       dual3_keep,
  input  logic       dual5_keep,
  input  logic       msel_hi,
  output logic [2:0] phase,
  output logic       ramp_go,
  output logic       fast_dis,
  output logic       cfg_stb,
  output logic       mon_sb_en,
  output logic       mon_main_en,
  output logic       main_sw_on,
  output logic       clk_rail_on,
  output logic       dual3_q,
  output logic       dual5_q,
  output logic       mem_3v3_q
);
  localparam logic [2:0] PH_RST  = 3'd0;
  localparam logic [2:0] PH_SB   = 3'd1;
  localparam logic [2:0] PH_WAIT = 3'd2;
  localparam logic [2:0] PH_MAIN = 3'd3;
  localparam logic [2:0] PH_RUN  = 3'd4;
  localparam int MAXC = (CFG_CYC > SETTLE_CYC) ? CFG_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] CFG_LAST    = CW'(CFG_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt;
  logic          cfg_done;
  logic          act_q;

  wire kill     = !bias_ok || shdn_req;
  wire wake_req = slp3_n && slp5_n;
  wire mains_ok = good_3v3 && good_5v && good_12v;

  assign ramp_go     = (phase == PH_SB) || (phase == PH_MAIN);
  assign main_sw_on  = act_q && ((phase == PH_MAIN) || (phase == PH_RUN));
  assign clk_rail_on = main_sw_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_RST;
      cnt         <= '0;
      cfg_done    <= 1'b0;
      act_q       <= 1'b0;
      fast_dis    <= 1'b0;
      cfg_stb     <= 1'b0;
      mon_sb_en   <= 1'b0;
      mon_main_en <= 1'b0;
      dual3_q     <= 1'b0;
      dual5_q     <= 1'b0;
      mem_3v3_q   <= 1'b0;
    end else begin
      fast_dis <= 1'b0;
      cfg_stb  <= 1'b0;
      if (kill) begin
        phase       <= PH_RST;
        cnt         <= '0;
        cfg_done    <= 1'b0;
        act_q       <= 1'b0;
        mon_sb_en   <= 1'b0;
        mon_main_en <= 1'b0;
      end else begin
        case (phase)
          PH_RST: phase <= PH_SB;
          PH_SB: if (ramp_top) begin
            phase     <= PH_WAIT;
            mon_sb_en <= 1'b1;
            fast_dis  <= 1'b1;
            cnt       <= '0;
            cfg_done  <= 1'b0;
          end
          PH_WAIT: begin
            if (!cfg_done) begin
              if (cnt == CFG_LAST) begin
                cfg_stb   <= 1'b1;
                cfg_done  <= 1'b1;
                cnt       <= '0;
                dual3_q   <= dual3_keep;
                dual5_q   <= dual5_keep;
                mem_3v3_q <= msel_hi;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end else if (!wake_req) begin
              phase <= PH_MAIN;
              act_q <= 1'b0;
            end else if (!mains_ok) begin
              cnt <= '0;
            end else if (cnt == SETTLE_LAST) begin
              phase <= PH_MAIN;
              act_q <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_MAIN: if (ramp_top) begin
            phase       <= PH_RUN;
            mon_main_en <= 1'b1;
            fast_dis    <= 1'b1;
          end
          default: phase <= PH_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/rail_startup_sequencer_chk.sv
`timescale 1ns/1ps
module rail_startup_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bias_ok,
  input logic       shdn_req,
  input logic [2:0] phase,
  input logic       ramp_go,
  input logic       fast_dis,
  input logic       cfg_stb,
  input logic       mon_sb_en,
  input logic       mon_main_en,
  input logic       main_sw_on,
  input logic       clk_rail_on,
  input logic       dual3_q,
  input logic       dual5_q,
  input logic       mem_3v3_q
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) |-> (!ramp_go && !main_sw_on && !mon_sb_en && !mon_main_en && !fast_dis && !cfg_stb)); // R1
  AST_KILL_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!bias_ok || shdn_req) |=> (phase == 3'd0)); // R1
  AST_DIS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fast_dis |=> !fast_dis); // R3
  AST_SB_ARM_WITH_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mon_sb_en) |-> (fast_dis && phase == 3'd2)); // R3
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_stb |=> !cfg_stb); // R4
  AST_SW_WITH_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_sw_on) |-> (ramp_go && phase == 3'd3)); // R6
  AST_SW_CLK_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    main_sw_on == clk_rail_on); // R6
  AST_MAIN_ARM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    mon_main_en |-> mon_sb_en); // R8
  AST_LATCH_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_stb |-> $stable({dual3_q, dual5_q, mem_3v3_q})); // R9
endmodule

bind rail_startup_sequencer rail_startup_sequencer_chk u_chk (.*);

// File: tb/sim_rail_startup_sequencer.sv
`timescale 1ns/1ps
module sim_rail_startup_sequencer;
  localparam int CFG = 6;
  localparam int SET = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bias_ok = 1'b0, shdn_req = 1'b1, slp3_n = 1'b1, slp5_n = 1'b1;
  logic good_3v3 = 1'b1, good_5v = 1'b1, good_12v = 1'b1, ramp_top = 1'b0;
  logic dual3_keep = 1'b0, dual5_keep = 1'b0, msel_hi = 1'b0;
  logic [2:0] phase;
  logic ramp_go, fast_dis, cfg_stb, mon_sb_en, mon_main_en, main_sw_on, clk_rail_on;
  logic dual3_q, dual5_q, mem_3v3_q;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rail_startup_sequencer #(.CFG_CYC(CFG), .SETTLE_CYC(SET)) u0 (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .shdn_req(shdn_req),
    .slp3_n(slp3_n), .slp5_n(slp5_n), .good_3v3(good_3v3), .good_5v(good_5v),
    .good_12v(good_12v), .ramp_top(ramp_top), .dual3_keep(dual3_keep),
    .dual5_keep(dual5_keep), .msel_hi(msel_hi), .phase(phase), .ramp_go(ramp_go),
    .fast_dis(fast_dis), .cfg_stb(cfg_stb), .mon_sb_en(mon_sb_en),
    .mon_main_en(mon_main_en), .main_sw_on(main_sw_on), .clk_rail_on(clk_rail_on),
    .dual3_q(dual3_q), .dual5_q(dual5_q), .mem_3v3_q(mem_3v3_q));

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic quiet(input string tag);
    chk({tag, " phase"}, phase, 0);
    chk({tag, " drives"}, {ramp_go, main_sw_on, clk_rail_on, fast_dis, cfg_stb}, 0);
    chk({tag, " monitors"}, {mon_sb_en, mon_main_en}, 0);
  endtask

  // from shutdown to the strobe; returns with the strobe visible
  task automatic to_strobe(input logic [2:0] cfgv, input string tag);
    shdn_req = 1'b1; step(); quiet("R1 shutdown");
    {dual3_keep, dual5_keep, msel_hi} = cfgv;
    shdn_req = 1'b0; step();
    chk({"R2 ", tag, " sb phase"}, phase, 1);
    chk({"R2 ", tag, " ramp_go"}, ramp_go, 1);
    chk({"R10 ", tag, " monitors off"}, {mon_sb_en, mon_main_en, main_sw_on}, 0);
    step(); chk({"R2 ", tag, " hold sb"}, phase, 1);
    ramp_top = 1'b1; step(); ramp_top = 1'b0;
    chk({"R3 ", tag, " wait"}, phase, 2);
    chk({"R3 ", tag, " arm sb"}, {mon_sb_en, mon_main_en}, 2);
    chk({"R3 ", tag, " dis"}, fast_dis, 1);
    for (int k = 1; k <= CFG; k++) begin
      step();
      if (k == 1) chk({"R3 ", tag, " dis one cycle"}, fast_dis, 0);
      chk({"R4 ", tag, " stb timing"}, cfg_stb, (k == CFG) ? 1 : 0);
    end
    chk({"R4 ", tag, " latched"}, {dual3_q, dual5_q, mem_3v3_q}, cfgv);
    {dual3_keep, dual5_keep, msel_hi} = ~cfgv;
  endtask

  task automatic finish_ramp(input logic [2:0] cfgv, input bit act, input string tag);
    step(); ramp_top = 1'b1; step(); ramp_top = 1'b0;
    chk({"R8 ", tag, " run"}, phase, 4);
    chk({"R8 ", tag, " arm"}, {mon_sb_en, mon_main_en}, 3);
    chk({"R8 ", tag, " dis"}, fast_dis, 1);
    step();
    chk({"R8 ", tag, " dis end"}, fast_dis, 0);
    chk({"R8 ", tag, " sw kept"}, {main_sw_on, clk_rail_on}, act ? 3 : 0);
    chk({"R9 ", tag, " latch kept"}, {dual3_q, dual5_q, mem_3v3_q}, cfgv);
    ramp_top = 1'b1; step(); ramp_top = 1'b0;
    chk({"R11 ", tag, " phase"}, phase, 4);
    chk({"R11 ", tag, " no dis"}, fast_dis, 0);
  endtask

  initial begin
    step(); quiet("R1 under reset");
    rst_n = 1'b1; bias_ok = 1'b1;
    step(); quiet("R1 held by shutdown");

    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 4; r++) begin
        automatic logic [2:0] cfgv = 3'(c);
        automatic bit act = (r == 3);
        {slp3_n, slp5_n} = 2'(r);
        to_strobe(cfgv, "sweep");
        if (act) begin
          for (int k = 1; k <= SET; k++) begin
            step();
            chk("R6 settle", phase, (k == SET) ? 3 : 2);
          end
          chk("R6 sw with ramp", {ramp_go, main_sw_on, clk_rail_on}, 3'b111);
        end else begin
          step();
          chk("R5 main", phase, 3);
          chk("R5 sw off", {ramp_go, main_sw_on, clk_rail_on}, 3'b100);
        end
        finish_ramp(cfgv, act, "sweep");
      end
    end

    {slp3_n, slp5_n} = 2'b11;
    for (int g = 0; g < 3; g++) begin
      for (int off = 0; off < SET - 1; off++) begin
        to_strobe(3'(g + off), "restart");
        for (int k = 0; k < off; k++) step();
        case (g)
          0: good_3v3 = 1'b0;
          1: good_5v  = 1'b0;
          default: good_12v = 1'b0;
        endcase
        step();
        {good_3v3, good_5v, good_12v} = 3'b111;
        chk("R7 still waiting", phase, 2);
        for (int k = 1; k <= SET; k++) begin
          step();
          chk("R7 restart count", phase, (k == SET) ? 3 : 2);
        end
      end
    end

    to_strobe(3'b101, "bias");
    for (int k = 0; k < SET; k++) step();
    finish_ramp(3'b101, 1'b1, "bias");
    bias_ok = 1'b0; step(); quiet("R1 bias loss");
    bias_ok = 1'b1; step();
    chk("R2 after bias return", phase, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule